// File: doc/BRIEF.md
# CPU Clock Stretcher with Boot Divider and Slow-Region Slowdown

This block derives the processor clock from a fast master clock. One master cycle is one fast half-period. At full speed the processor clock has a low phase (phase 1) of one master cycle and a high phase (phase 2) of one master cycle. From reset the block runs in a boot mode in which every processor cycle lasts `2*BOOT_DIV` master cycles, so that start-up code can execute from slow read-only memory while it copies itself into RAM. A single write strobe to a one-bit speed register then switches to full speed, and the block stays at full speed until the next reset.

Address decode supplies a slow-region request for the expansion slots. When that request is seen during phase 1, the block lengthens the current cycle to `2*SLOT_DIV` master cycles, which is one sixteenth of the full rate with the default value. Every slowdown lengthens phase 1 only. Phase 2 always lasts one master cycle, so no switch of the divide ratio can produce a short pulse. A second output is a peripheral clock with a fixed rate. It keeps running at the same rate whatever the processor clock does, so the peripheral timers keep counting at a steady rate.

Top module: `clkslow_ctrl`

## Requirements
- R1: While reset is high, `phi2_o` and `periph_clk_o` are both low. The first processor cycle after reset is in boot mode.
- R2: In boot mode every processor cycle has phase 1 low for `2*BOOT_DIV-1` master cycles (15 by default) and phase 2 high for 1 master cycle. This repeats until a speed write.
- R3: A one-cycle pulse on `warp_wr_i` selects full speed: phase 1 lasts 1 master cycle and phase 2 lasts 1 master cycle. Full speed holds until reset, and later pulses change nothing.
- R4: A speed write changes the cycle length only from the start of a phase 1. A write sampled during phase 1 leaves the current cycle at boot length, and the next cycle runs at full speed. A write sampled on the edge that ends phase 2 takes effect one cycle later.
- R5: When `slot_slow_i` is high at any master edge during phase 1, that cycle's phase 1 lasts `2*SLOT_DIV-1` master cycles (31 by default), in either mode. The next cycle without a request returns to the length of the current mode.
- R6: `slot_slow_i` is sampled only during phase 1. A request that is high only during phase 2 leaves both the current cycle and the next cycle unchanged.
- R7: A request that first appears late in a boot-mode phase 1 still stretches that phase 1 to `2*SLOT_DIV-1` master cycles. This holds up to and including its last master cycle.
- R8: Phase 2 always lasts exactly one master cycle, and phase 1 never lasts less than one master cycle. So no high or low pulse is shorter than a fast half-period.
- R9: `periph_clk_o` toggles every `PER_HALF` master cycles (every cycle by default), whatever the mode and whatever slowdowns are active.
- R10: Asserting reset in the middle of operation clears the full-speed selection, and the block returns to boot-mode cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast master clock; one period is one fast half-period |
| rst_i | input | 1 | Synchronous reset, active high |
| slot_slow_i | input | 1 | Slow-region request from address decode (expansion slots) |
| warp_wr_i | input | 1 | One-cycle write strobe of the full-speed register |
| phi2_o | output | 1 | Processor clock; low is phase 1, high is phase 2 |
| periph_clk_o | output | 1 | Fixed-rate peripheral clock |

## Verification
The bench builds the block with its default parameters: `BOOT_DIV` 8, `SLOT_DIV` 16 and `PER_HALF` 1. With these values a boot cycle lasts 16 master cycles and a slot cycle lasts 32. This makes it cheap to place a slow request at every interesting position: the first low cycle, a middle one, the very last low cycle, and phase 2 only. The same values let the bench place a speed write either inside phase 1 or on the phase-2 edge, and count the exact number of cycles before it takes effect. With `PER_HALF` at 1 the peripheral clock must change on every master edge, so any stall during a stretched cycle shows up directly at the port.

// File: rtl/clkslow_pkg.sv
`timescale 1ns/1ps
package clkslow_pkg;

    // Speed mode of the processor clock.
    typedef enum logic {
        MODE_BOOT = 1'b0,
        MODE_FULL = 1'b1
    } speed_mode_e;

    // Number of phase-1 master cycles for a clock divided by div.
    // Phase 2 always takes exactly one master cycle.
    function automatic int low_len(input int div);
        return 2 * div - 1;
    endfunction

endpackage

// File: rtl/clkslow_warp.sv
`timescale 1ns/1ps
module clkslow_warp
    import clkslow_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        warp_wr_i,
    output speed_mode_e mode_o
);

    typedef struct packed {
        logic full;
    } warp_state_t;

    warp_state_t st_q, st_d;

    // Next state: the full-speed flag is sticky until reset.
    always_comb begin
        st_d = st_q;
        if (warp_wr_i) begin
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.full ? MODE_FULL : MODE_BOOT;

    // R3: once full speed is selected it stays until reset.
    assert_warp_sticky_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_o == MODE_FULL) |=> (mode_o == MODE_FULL));

    // R3: a speed write is registered on the following edge.
    assert_warp_capture_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        warp_wr_i |=> (mode_o == MODE_FULL));

endmodule

// File: rtl/clkslow_phase.sv
`timescale 1ns/1ps
module clkslow_phase
    import clkslow_pkg::*;
#(
    parameter int BOOT_DIV = 8,
    parameter int SLOT_DIV = 16
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  speed_mode_e mode_i,
    input  logic        slot_req_i,
    output logic        phi2_o
);

    localparam int CW = $clog2(2 * SLOT_DIV);
    localparam logic [CW-1:0] FAST_LO = CW'(low_len(1));
    localparam logic [CW-1:0] BOOT_LO = CW'(low_len(BOOT_DIV));
    localparam logic [CW-1:0] SLOT_LO = CW'(low_len(SLOT_DIV));

    typedef struct packed {
        logic          phi2;     // processor clock level
        logic          stretch;  // slot request seen in this phase 1
        logic [CW-1:0] base_lo;  // phase-1 length chosen at phase-1 start
        logic [CW-1:0] cnt;      // master cycles spent in phase 1
    } phase_state_t;

    phase_state_t st_q, st_d;
    logic          stretch_now;
    logic [CW-1:0] target_lo;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        st_d        = st_q;
        stretch_now = st_q.stretch | slot_req_i;
        target_lo   = stretch_now ? SLOT_LO : st_q.base_lo;
        cnt_inc     = st_q.cnt + CW'(1);
        if (!st_q.phi2) begin
            // Phase 1: the slot request is sampled on every edge here.
            if (cnt_inc >= target_lo) begin
                st_d.phi2    = 1'b1;
                st_d.cnt     = '0;
                st_d.stretch = 1'b0;
            end else begin
                st_d.cnt     = cnt_inc;
                st_d.stretch = stretch_now;
            end
        end else begin
            // Phase 2 is a single master cycle; choose the next base length.
            st_d.phi2    = 1'b0;
            st_d.cnt     = '0;
            st_d.stretch = 1'b0;
            st_d.base_lo = (mode_i == MODE_FULL) ? FAST_LO : BOOT_LO;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.phi2    <= 1'b0;
            st_q.stretch <= 1'b0;
            st_q.base_lo <= BOOT_LO;
            st_q.cnt     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phi2_o = st_q.phi2;

    // R8: phase 2 never lasts more or less than one master cycle.
    assert_phase2_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.phi2 |=> !st_q.phi2);

    // R5: phase-1 count never runs past the longest stretch.
    assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        !st_q.phi2 |-> (st_q.cnt < SLOT_LO));

    // R4: the base length only changes at a phase-1 start.
    assert_base_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !st_q.phi2 |=> $stable(st_q.base_lo));

    // R6: a request seen during phase 2 does not stretch the next cycle.
    assert_no_late_stretch_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.phi2 |=> !st_q.stretch);

    // R3: at full speed without a request phase 1 ends after one cycle.
    assert_fast_low_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!st_q.phi2 && st_q.base_lo == FAST_LO && !st_q.stretch && !slot_req_i)
        |=> st_q.phi2);

endmodule

// File: rtl/clkslow_periph.sv
`timescale 1ns/1ps
module clkslow_periph #(
    parameter int PER_HALF = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic periph_o
);

    generate
        if (PER_HALF == 1) begin : g_toggle
            typedef struct packed {
                logic level;
            } tog_state_t;

            tog_state_t st_q, st_d;

            always_comb begin
                st_d       = st_q;
                st_d.level = ~st_q.level;
            end

            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign periph_o = st_q.level;

            // R9: the peripheral clock changes on every master edge.
            assert_periph_toggle_R9: assert property (@(posedge clk_i) disable iff (rst_i)
                !$past(rst_i) |-> (periph_o != $past(periph_o)));
        end else begin : g_count
            localparam int PW = $clog2(PER_HALF);
            localparam logic [PW-1:0] LAST = PW'(PER_HALF - 1);

            typedef struct packed {
                logic          level;
                logic [PW-1:0] cnt;
            } div_state_t;

            div_state_t st_q, st_d;

            always_comb begin
                st_d = st_q;
                if (st_q.cnt == LAST) begin
                    st_d.cnt   = '0;
                    st_d.level = ~st_q.level;
                end else begin
                    st_d.cnt = st_q.cnt + PW'(1);
                end
            end

            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign periph_o = st_q.level;

            // R9: the divider count stays inside its half-period.
            assert_periph_bound_R9: assert property (@(posedge clk_i) disable iff (rst_i)
                st_q.cnt <= LAST);
        end
    endgenerate

endmodule

// File: rtl/clkslow_ctrl.sv
`timescale 1ns/1ps
module clkslow_ctrl
    import clkslow_pkg::*;
#(
    parameter int BOOT_DIV = 8,
    parameter int SLOT_DIV = 16,
    parameter int PER_HALF = 1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic slot_slow_i,
    input  logic warp_wr_i,
    output logic phi2_o,
    output logic periph_clk_o
);

    speed_mode_e mode;

    clkslow_warp u_warp (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .warp_wr_i (warp_wr_i),
        .mode_o    (mode)
    );

    clkslow_phase #(
        .BOOT_DIV (BOOT_DIV),
        .SLOT_DIV (SLOT_DIV)
    ) u_phase (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .mode_i     (mode),
        .slot_req_i (slot_slow_i),
        .phi2_o     (phi2_o)
    );

    clkslow_periph #(
        .PER_HALF (PER_HALF)
    ) u_periph (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .periph_o (periph_clk_o)
    );

    // R1: outputs are low while reset is held (checked after the reset edge).
    assert_reset_low_R1: assert property (@(posedge clk_i)
        $past(rst_i) |-> (!phi2_o && !periph_clk_o));

endmodule

// File: tb/clkslow_ctrl_tb.sv
`timescale 1ns/1ps
module clkslow_ctrl_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slot = 1'b0;
    logic warp = 1'b0;
    logic phi2;
    logic pclk;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #4 clk = ~clk;

    clkslow_ctrl u_dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .slot_slow_i  (slot),
        .warp_wr_i    (warp),
        .phi2_o       (phi2),
        .periph_clk_o (pclk)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Runs one processor cycle starting at a negedge where phase 1 begins.
    task automatic run_cycle(input int req_from, input bit late, input int warp_at,
                             input bit warp_hi, output int lo, output int hi);
        lo = 0;
        hi = 0;
        while (phi2 == 1'b0 && lo < 100) begin
            warp = (lo == warp_at);
            slot = (req_from >= 0 && lo >= req_from);
            lo++;
            @(negedge clk);
        end
        while (phi2 == 1'b1 && hi < 100) begin
            warp = warp_hi;
            slot = late;
            hi++;
            @(negedge clk);
        end
        warp = 1'b0;
        slot = 1'b0;
    endtask

    task automatic expect_cycle(input string req, input int req_from, input bit late,
                                input int warp_at, input bit warp_hi, input int lo_exp);
        int lo, hi;
        run_cycle(req_from, late, warp_at, warp_hi, lo, hi);
        check(req, "phase-1 length", lo, lo_exp);
        check("R8", "phase-2 length", hi, 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        slot = 1'b0;
        warp = 1'b0;
        repeat (4) @(negedge clk);
        check("R1", "phi2 in reset", int'(phi2), 0);
        check("R1", "periph clock in reset", int'(pclk), 0);
        rst = 1'b0;
    endtask

    task automatic t_boot();
        do_reset();
        expect_cycle("R1", -1, 1'b0, -1, 1'b0, 15);
        expect_cycle("R2", -1, 1'b0, -1, 1'b0, 15);
        expect_cycle("R2", -1, 1'b0, -1, 1'b0, 15);
    endtask

    task automatic t_boot_slot();
        expect_cycle("R5", 0, 1'b0, -1, 1'b0, 31);
        expect_cycle("R5", -1, 1'b0, -1, 1'b0, 15);
    endtask

    task automatic t_mid_request();
        expect_cycle("R7", 7, 1'b0, -1, 1'b0, 31);
        expect_cycle("R7", 14, 1'b0, -1, 1'b0, 31);
    endtask

    task automatic t_late_boot();
        expect_cycle("R6", -1, 1'b1, -1, 1'b0, 15);
        expect_cycle("R6", -1, 1'b0, -1, 1'b0, 15);
    endtask

    task automatic t_periph();
        logic prev;
        slot = 1'b1;
        prev = pclk;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check("R9", "peripheral clock toggled", int'(pclk != prev), 1);
            prev = pclk;
        end
        slot = 1'b0;
        // realign to the start of a phase 1
        for (int i = 0; i < 100 && phi2 == 1'b0; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_warp_in_low();
        expect_cycle("R4", -1, 1'b0, 3, 1'b0, 15);
        expect_cycle("R3", -1, 1'b0, -1, 1'b0, 1);
        expect_cycle("R3", -1, 1'b0, -1, 1'b0, 1);
    endtask

    task automatic t_fast_slot();
        expect_cycle("R5", 0, 1'b0, -1, 1'b0, 31);
        expect_cycle("R5", -1, 1'b0, -1, 1'b0, 1);
        expect_cycle("R6", -1, 1'b1, -1, 1'b0, 1);
        expect_cycle("R6", -1, 1'b0, -1, 1'b0, 1);
    endtask

    task automatic t_warp_repeat();
        expect_cycle("R3", -1, 1'b0, 0, 1'b0, 1);
        expect_cycle("R3", -1, 1'b0, -1, 1'b1, 1);
        expect_cycle("R3", -1, 1'b0, -1, 1'b0, 1);
    endtask

    task automatic t_reset_midrun();
        do_reset();
        expect_cycle("R10", -1, 1'b0, -1, 1'b0, 15);
        expect_cycle("R10", -1, 1'b0, -1, 1'b0, 15);
    endtask

    task automatic t_warp_on_edge();
        expect_cycle("R4", -1, 1'b0, -1, 1'b1, 15);
        expect_cycle("R4", -1, 1'b0, -1, 1'b0, 15);
        expect_cycle("R4", -1, 1'b0, -1, 1'b0, 1);
    endtask

    initial begin
        t_boot();
        t_boot_slot();
        t_mid_request();
        t_late_boot();
        t_periph();
        t_warp_in_low();
        t_fast_slot();
        t_warp_repeat();
        t_reset_midrun();
        t_warp_on_edge();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule